// File: doc/BRIEF.md
# Line-to-Way Lookup Table

This block is a small, fully associative table that sits in front of a set-associative data cache and remembers, for recently used cache line addresses, which way holds each line. Before a cache access the line address is presented on the lookup port. On a hit the cache controller can enable a single way for both the tag and the data arrays. On a miss it enables all ways in parallel. A hit is never a guess: it is returned only for a line whose way was recorded earlier.

When the table misses, the controller issues a claim for the line. The claim reserves an entry at once, in FIFO order set by a wrapping slot counter, or reuses the entry that already holds that line. The entry stays pending and produces no hit until the controller later issues a fill that carries the resolved way. Entries are never invalidated from outside. If a line has moved, the single-way access misses in the cache, the controller claims the line again, and the entry is rewritten in place with the new way.

Lookup is combinational from the stored state. Claims and fills take effect at the next rising clock edge. The entry count, line address width and way field width are parameters. The defaults are 16 entries, a 27-bit line address and a 5-bit way field.

Top module: `line_way_table`

## Requirements
- R1: `lk_hit` is 1 only when `lk_req` is 1 and a filled entry's stored line equals `lk_line`. `lk_way` then carries that entry's way. When `lk_hit` is 0, `lk_way` is 0.
- R2: A claim for a line that no entry holds writes the line into the slot the FIFO counter points at. The old contents of that slot are discarded. The new entry gives no hit until it is filled.
- R3: A fill whose line matches a claimed entry stores `fill_way` there and makes the entry hit from the next cycle on.
- R4: A fill whose line matches no claimed entry changes nothing. Lookups of every line give the same results as before the fill.
- R5: A claim for a line that already has an entry, pending or filled, reuses that entry. The entry becomes pending again and the FIFO counter does not move. No duplicate entry is created.
- R6: The FIFO counter advances by one only on a claim that takes a new slot. After slot ENTRIES-1 it wraps to slot 0, so the oldest allocation is always the next victim.
- R7: Reset makes every entry empty and sets the FIFO counter to slot 0. After reset every lookup misses, and the first claim goes to slot 0.
- R8: When a claim and a fill for the same line fall in the same cycle, the claim wins and the entry is left pending.
- R9: A filled entry keeps returning its way until a claim rewrites it. After a reuse claim and a new fill, lookups return the new way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_line | input | TAG_W | Line address to look up |
| lk_hit | output | 1 | Line found in a filled entry |
| lk_way | output | WAY_W | Way of the matching line, 0 on miss |
| claim_req | input | 1 | Reserve an entry for a line |
| claim_line | input | TAG_W | Line address being claimed |
| fill_req | input | 1 | Record the resolved way of a claimed line |
| fill_line | input | TAG_W | Line address being filled |
| fill_way | input | WAY_W | Way resolved by the cache controller |

## Verification
The assertions check three properties on every cycle. No two entries ever hold the same line. A line claimed in one cycle never hits in the next. A fill that lands is visible with its way on a lookup in the following cycle. They also check that the FIFO counter stays in range, holds when no new slot is taken, and moves when one is. Only the bench's scenarios can show which entry a claim evicts. These include the FIFO order across a wrap, the counter staying put on a reuse claim, and the later eviction landing on the right older line. The scenarios also show that a stray fill leaves everything untouched.

// File: rtl/wt_pkg.sv
package wt_pkg;

  // Next FIFO slot: one step forward, back to zero past the last entry.
  function automatic int unsigned slot_after(int unsigned cur, int unsigned entries);
    return (cur + 1 >= entries) ? 0 : cur + 1;
  endfunction

  // Width of a slot index for a given entry count (at least one bit).
  function automatic int unsigned idx_bits(int unsigned entries);
    return (entries <= 2) ? 1 : $clog2(entries);
  endfunction

endpackage

// File: rtl/wt_fifo_ptr.sv
module wt_fifo_ptr #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W = wt_pkg::idx_bits(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= IDX_W'(wt_pkg::slot_after(int'(ptr), ENTRIES));
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < int'(ENTRIES));                                          // R6
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));                                              // R5
  AST_PTR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ptr != $past(ptr));                                          // R6

endmodule

// File: rtl/wt_store.sv
module wt_store #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 27,
  parameter int unsigned WAY_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] claim_we,
  input  logic [TAG_W-1:0]   claim_line,
  input  logic [ENTRIES-1:0] fill_we,
  input  logic [WAY_W-1:0]   fill_way,
  output logic [TAG_W-1:0]   tags [ENTRIES],
  output logic [WAY_W-1:0]   ways [ENTRIES],
  output logic [ENTRIES-1:0] used,
  output logic [ENTRIES-1:0] live
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tags[i] <= '0;
        ways[i] <= '0;
        used[i] <= 1'b0;
        live[i] <= 1'b0;
      end else if (claim_we[i]) begin
        tags[i] <= claim_line;
        used[i] <= 1'b1;
        live[i] <= 1'b0;
      end else if (fill_we[i]) begin
        ways[i] <= fill_way;
        live[i] <= 1'b1;
      end
    end
  end

  AST_LIVE_IMPLIES_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (live & ~used) == '0);                                               // R3

endmodule

// File: rtl/wt_cam.sv
module wt_cam #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 27
) (
  input  logic [TAG_W-1:0]   tags [ENTRIES],
  input  logic [ENTRIES-1:0] used,
  input  logic [TAG_W-1:0]   lk_line,
  input  logic [TAG_W-1:0]   claim_line,
  input  logic [TAG_W-1:0]   fill_line,
  output logic [ENTRIES-1:0] lk_match,
  output logic [ENTRIES-1:0] claim_match,
  output logic [ENTRIES-1:0] fill_match
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_match[i]    = used[i] && (tags[i] == lk_line);
    assign claim_match[i] = used[i] && (tags[i] == claim_line);
    assign fill_match[i]  = used[i] && (tags[i] == fill_line);
  end

endmodule

// File: rtl/line_way_table.sv
module line_way_table #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 27,
  parameter int unsigned WAY_W   = 5,
  localparam int unsigned IDX_W  = wt_pkg::idx_bits(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [TAG_W-1:0] lk_line,
  output logic             lk_hit,
  output logic [WAY_W-1:0] lk_way,
  input  logic             claim_req,
  input  logic [TAG_W-1:0] claim_line,
  input  logic             fill_req,
  input  logic [TAG_W-1:0] fill_line,
  input  logic [WAY_W-1:0] fill_way
);

  logic [TAG_W-1:0]   tags [ENTRIES];
  logic [WAY_W-1:0]   ways [ENTRIES];
  logic [ENTRIES-1:0] used, live;
  logic [ENTRIES-1:0] lk_match, claim_match, fill_match;
  logic [ENTRIES-1:0] claim_we, fill_we, lk_sel;
  logic [IDX_W-1:0]   victim;

  // Named internal events for the assertions.
  logic claim_reuse, claim_fresh, fill_lands;

  wt_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) i_cam (
    .tags(tags), .used(used),
    .lk_line(lk_line), .claim_line(claim_line), .fill_line(fill_line),
    .lk_match(lk_match), .claim_match(claim_match), .fill_match(fill_match)
  );

  assign claim_reuse = claim_req && (|claim_match);
  assign claim_fresh = claim_req && !(|claim_match);

  wt_fifo_ptr #(.ENTRIES(ENTRIES)) i_ptr (
    .clk(clk), .rst_n(rst_n), .adv(claim_fresh), .ptr(victim)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_we
    assign claim_we[i] = claim_reuse ? claim_match[i]
                                     : (claim_fresh && (int'(victim) == i));
    assign fill_we[i]  = fill_req && fill_match[i] && !claim_we[i];
  end
  assign fill_lands = |fill_we;

  wt_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .WAY_W(WAY_W)) i_store (
    .clk(clk), .rst_n(rst_n),
    .claim_we(claim_we), .claim_line(claim_line),
    .fill_we(fill_we), .fill_way(fill_way),
    .tags(tags), .ways(ways), .used(used), .live(live)
  );

  assign lk_sel = lk_req ? (lk_match & live) : '0;
  assign lk_hit = |lk_sel;

  always_comb begin
    lk_way = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_sel[i]) lk_way = lk_way | ways[i];
  end

  AST_NO_DUP_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match) && $onehot0(claim_match));                         // R5
  AST_PENDING_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    claim_req |=> !(lk_req && lk_line == $past(claim_line) && lk_hit));  // R2
  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_lands |=> (!(lk_req && lk_line == $past(fill_line))
                    || (lk_hit && lk_way == $past(fill_way))));          // R3
  AST_MISS_WAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_way == '0);                                           // R1

endmodule

// File: tb/test_line_way_table.sv
module test_line_way_table;
  localparam int unsigned ENTRIES = 16;
  localparam int unsigned TAG_W   = 27;
  localparam int unsigned WAY_W   = 5;
  localparam time         PERIOD  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_req = 1'b0, claim_req = 1'b0, fill_req = 1'b0;
  logic [TAG_W-1:0] lk_line = '0, claim_line = '0, fill_line = '0;
  logic [WAY_W-1:0] fill_way = '0;
  logic lk_hit;
  logic [WAY_W-1:0] lk_way;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  line_way_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .WAY_W(WAY_W)) i_line_way_table (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_line(lk_line), .lk_hit(lk_hit), .lk_way(lk_way),
    .claim_req(claim_req), .claim_line(claim_line),
    .fill_req(fill_req), .fill_line(fill_line), .fill_way(fill_way)
  );

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One clock of claim and/or fill; inputs are set at the falling edge.
  task automatic step(input logic c, input logic [TAG_W-1:0] cl,
                      input logic f, input logic [TAG_W-1:0] fl,
                      input logic [WAY_W-1:0] fw);
    @(negedge clk);
    claim_req = c; claim_line = cl;
    fill_req = f; fill_line = fl; fill_way = fw;
    @(posedge clk); #1;
    claim_req = 1'b0; fill_req = 1'b0;
  endtask

  task automatic look(input string req, input logic rq, input logic [TAG_W-1:0] ln,
                      input logic eh, input logic [WAY_W-1:0] ew);
    @(negedge clk);
    lk_req = rq; lk_line = ln;
    #1;
    checks++;
    if (lk_hit !== eh || lk_way !== ew) begin
      fails++;
      $display("FAIL %s line=%h hit=%b way=%0d expected hit=%b way=%0d",
               req, ln, lk_hit, lk_way, eh, ew);
    end
    lk_req = 1'b0;
  endtask

  // R7: nothing hits after reset, even after a populated table is reset.
  task automatic t_reset();
    do_reset();
    look("R7", 1, 27'h0000000, 0, 0);
    look("R7", 1, 27'h1234567, 0, 0);
    step(1, 27'h00000a1, 0, '0, '0);
    step(0, '0, 1, 27'h00000a1, 5'd4);
    look("R7", 1, 27'h00000a1, 1, 5'd4);
    do_reset();
    look("R7", 1, 27'h00000a1, 0, 0);
  endtask

  // R1 R2 R3: pending entry is silent, a fill makes it hit.
  task automatic t_basic();
    do_reset();
    step(1, 27'h0abcdef, 0, '0, '0);
    look("R2", 1, 27'h0abcdef, 0, 0);
    step(0, '0, 1, 27'h0abcdef, 5'd7);
    look("R3", 1, 27'h0abcdef, 1, 5'd7);
    look("R1", 1, 27'h0abcdee, 0, 0);
    look("R1", 0, 27'h0abcdef, 0, 0);
  endtask

  // R4: a fill for an unknown line changes nothing.
  task automatic t_stray_fill();
    step(0, '0, 1, 27'h0000055, 5'd3);
    look("R4", 1, 27'h0000055, 0, 0);
    look("R4", 1, 27'h0abcdef, 1, 5'd7);
  endtask

  // R8: claim and fill of the same line in one cycle leaves it pending.
  task automatic t_same_cycle();
    step(1, 27'h0000777, 0, '0, '0);
    step(0, '0, 1, 27'h0000777, 5'd2);
    look("R8", 1, 27'h0000777, 1, 5'd2);
    step(1, 27'h0000777, 1, 27'h0000777, 5'd9);
    look("R8", 1, 27'h0000777, 0, 0);
    step(0, '0, 1, 27'h0000777, 5'd9);
    look("R8", 1, 27'h0000777, 1, 5'd9);
  endtask

  // R6 R5 R9: FIFO order, reuse in place, and wrap.
  task automatic t_fifo_reuse();
    logic [TAG_W-1:0] base = 27'h0100000;
    logic [TAG_W-1:0] x = 27'h0200000;
    logic [TAG_W-1:0] y = 27'h0300000;
    logic [TAG_W-1:0] z = 27'h0400000;
    do_reset();
    for (int i = 0; i < int'(ENTRIES); i++) begin
      step(1, base + TAG_W'(i), 0, '0, '0);
      step(0, '0, 1, base + TAG_W'(i), WAY_W'(i + 1));
    end
    look("R6", 1, base + 27'd0, 1, 5'd1);
    look("R6", 1, base + 27'd15, 1, 5'd16);
    // Table full, counter back at slot 0: new line evicts the oldest.
    step(1, x, 0, '0, '0);
    step(0, '0, 1, x, 5'd30);
    look("R6", 1, base + 27'd0, 0, 0);
    look("R6", 1, base + 27'd1, 1, 5'd2);
    look("R6", 1, x, 1, 5'd30);
    // Reuse claim: pending, then rewritten way; counter stays at slot 1.
    step(1, base + 27'd5, 0, '0, '0);
    look("R5", 1, base + 27'd5, 0, 0);
    step(0, '0, 1, base + 27'd5, 5'd21);
    look("R9", 1, base + 27'd5, 1, 5'd21);
    step(1, y, 0, '0, '0);
    step(0, '0, 1, y, 5'd11);
    look("R5", 1, base + 27'd1, 0, 0);
    look("R5", 1, base + 27'd2, 1, 5'd3);
    look("R5", 1, y, 1, 5'd11);
    // Fill slots 2..15, then the next new line wraps to slot 0 (holds x).
    for (int k = 0; k < int'(ENTRIES) - 2; k++) begin
      step(1, z + TAG_W'(k), 0, '0, '0);
      step(0, '0, 1, z + TAG_W'(k), WAY_W'(k));
    end
    look("R6", 1, x, 1, 5'd30);
    step(1, 27'h0500000, 0, '0, '0);
    look("R6", 1, x, 0, 0);
    look("R6", 1, y, 1, 5'd11);
    look("R6", 1, z + 27'd13, 1, 5'd13);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_stray_fill();
    t_same_cycle();
    t_fifo_reuse();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule